// File: doc/BRIEF.md
# Six-Stage Fragment Color Combiner

This block blends the colour of one fragment through a fixed chain of six combiner stages. Every stage picks three RGBA operands. An operand can be one of the primary colour vectors, the stage's own constant, the result of the stage before it, or a shared scratch colour called the combiner buffer. The stage applies one of four operations to each channel, multiplies the result by a per-stage scale factor and saturates it to 8 bits.

The combiner buffer is loaded from a seed colour at the start of every fragment. The first four stages may overwrite it. Separate masks control the RGB part and the alpha part, so a colour that an early stage computes can be used again by a later stage. The whole chain is combinational. It is evaluated when a fragment is presented, and its result is captured into an output register together with a valid flag.

Top module: `frag_combiner`

## Requirements
- R1: After reset, out_valid is 0 and out_rgba is 0.
- R2: A fragment presented with in_valid high gives its result on out_rgba one clock later, with out_valid high for exactly that cycle. out_valid is low one cycle after in_valid is low.
- R3: While in_valid is low, out_rgba keeps its last value, whatever the other inputs do.
- R4: Operand select codes are 4 bits wide. Codes 0 to NPRIM-1 pick primary vector i, held at prim[32i+31:32i]. 0xd picks the combiner buffer, 0xe picks the stage constant, and 0xf picks the previous stage's result, which is zero for stage 0. Any other code gives zero.
- R5: The stage control word holds operand A in [3:0], operand B in [7:4], operand C in [11:8] and the operation in [13:12]. The operations are: 0 = A; 1 = A+B saturated at 255; 2 = A+B-128 clamped to 0..255; 3 = (A*C + B*(255-C))/255 with truncation. Each is applied to every channel, and alpha uses the same operation as RGB.
- R6: The stage scale word holds the RGB scale in [1:0] and the alpha scale in [17:16]. Values 0, 1, 2 and 3 multiply by 1, 2, 4 and 1. The product is clamped to 255.
- R7: The buffer starts each fragment as buf_seed, where r is [7:0], g is [15:8], b is [23:16] and a is [31:24]. Every RGBA vector in the block uses this layout.
- R8: When bit 8+k of buf_mask is set, stage k (k = 0..3) writes its RGB result to the buffer. When bit 12+k is set, it writes its alpha. A stage's own operands see the buffer as it was before that stage's write. Later stages see the updated value.
- R9: The RGB and alpha buffer updates are independent of each other. A stage that writes only one part leaves the other part of the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A fragment is presented this cycle |
| prim | input | NPRIM*32 | Primary colour vectors |
| stage_ctrl | input | NSTAGE*14 | Per-stage operand selects and operation |
| stage_scale | input | NSTAGE*18 | Per-stage RGB and alpha scale |
| stage_const | input | NSTAGE*32 | Per-stage constant colour |
| buf_seed | input | 32 | Initial combiner buffer colour |
| buf_mask | input | 32 | Buffer write masks (RGB [11:8], alpha [15:12]) |
| out_valid | output | 1 | out_rgba holds a new result |
| out_rgba | output | 32 | Final combined colour |

## Verification
Each result appears one clock edge after the fragment is presented, because only the output register lies between the inputs and out_rgba. The bench changes inputs on the falling edge, lets one rising edge pass, and reads out_valid and out_rgba on the next falling edge. To check holding, it then drops in_valid, scrambles every other input, waits one more full cycle and checks that out_rgba has not moved and out_valid is low.

// File: rtl/frag_combiner.sv
module frag_combiner #(
  parameter int NSTAGE = 6,
  parameter int NPRIM  = 4,
  parameter int NUPD   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [NPRIM*32-1:0]     prim,
  input  logic [NSTAGE*14-1:0]    stage_ctrl,
  input  logic [NSTAGE*18-1:0]    stage_scale,
  input  logic [NSTAGE*32-1:0]    stage_const,
  input  logic [31:0]             buf_seed,
  input  logic [31:0]             buf_mask,
  output logic                    out_valid,
  output logic [31:0]             out_rgba
);
  localparam int CW = 14;
  localparam int SW = 18;

  logic [31:0] prev_c [NSTAGE+1];
  logic [31:0] buf_c  [NSTAGE+1];
  logic [3:0]  msk_rgb, msk_a;

  assign msk_rgb   = buf_mask[11:8];
  assign msk_a     = buf_mask[15:12];
  assign prev_c[0] = '0;
  assign buf_c[0]  = buf_seed;

  function automatic logic [31:0] pick(input logic [3:0] sel, input logic [NPRIM*32-1:0] pv,
                                       input logic [31:0] cst, input logic [31:0] prv,
                                       input logic [31:0] bf);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < NPRIM; i++)
      if (sel == 4'(i)) r = pv[i*32 +: 32];
    case (sel)
      4'hd: r = bf;
      4'he: r = cst;
      4'hf: r = prv;
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] comb_ch(input logic [1:0] op, input logic [7:0] a,
                                         input logic [7:0] b, input logic [7:0] c,
                                         input logic [1:0] scl);
    logic [17:0] t, s, p;
    s = {10'd0, a} + {10'd0, b};
    case (op)
      2'd0: t = {10'd0, a};
      2'd1: t = (s > 18'd255) ? 18'd255 : s;
      2'd2: t = (s < 18'd128) ? 18'd0 : ((s - 18'd128 > 18'd255) ? 18'd255 : s - 18'd128);
      default: t = ({10'd0, a} * {10'd0, c} + {10'd0, b} * (18'd255 - {10'd0, c})) / 18'd255;
    endcase
    case (scl)
      2'd1:    p = t << 1;
      2'd2:    p = t << 2;
      default: p = t;
    endcase
    return (p > 18'd255) ? 8'hff : p[7:0];
  endfunction

  logic unused_bits;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    logic [CW-1:0] ctl;
    logic [SW-1:0] scw;
    logic [31:0]   va, vb, vc, res;
    assign ctl = stage_ctrl[s*CW +: CW];
    assign scw = stage_scale[s*SW +: SW];
    assign va  = pick(ctl[3:0],  prim, stage_const[s*32 +: 32], prev_c[s], buf_c[s]);
    assign vb  = pick(ctl[7:4],  prim, stage_const[s*32 +: 32], prev_c[s], buf_c[s]);
    assign vc  = pick(ctl[11:8], prim, stage_const[s*32 +: 32], prev_c[s], buf_c[s]);
    for (genvar ch = 0; ch < 4; ch++) begin : g_ch
      assign res[ch*8 +: 8] = comb_ch(ctl[13:12], va[ch*8 +: 8], vb[ch*8 +: 8], vc[ch*8 +: 8],
                                      (ch == 3) ? scw[17:16] : scw[1:0]);
    end
    assign prev_c[s+1] = res;
    if (s < NUPD) begin : g_upd
      assign buf_c[s+1] = {msk_a[s] ? res[31:24] : buf_c[s][31:24],
                           msk_rgb[s] ? res[23:0] : buf_c[s][23:0]};
    end else begin : g_keep
      assign buf_c[s+1] = buf_c[s];
    end
  end

  logic [NSTAGE*14-1:0] scale_spare;
  for (genvar s = 0; s < NSTAGE; s++) begin : g_spare
    assign scale_spare[s*14 +: 14] = stage_scale[s*SW+2 +: 14];
  end
  assign unused_bits = ^{scale_spare, buf_mask[31:16], buf_mask[7:0], buf_c[NSTAGE]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgba  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_rgba <= prev_c[NSTAGE];
    end
  end
endmodule

// File: rtl/frag_combiner_chk.sv
module frag_combiner_chk #(
  parameter int NSTAGE = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [NSTAGE*14-1:0] stage_ctrl,
  input logic [NSTAGE*18-1:0] stage_scale,
  input logic [NSTAGE*32-1:0] stage_const,
  input logic [31:0]          buf_seed,
  input logic [31:0]          buf_mask,
  input logic                 out_valid,
  input logic [31:0]          out_rgba
);
  logic [13:0] last_ctl;
  logic [17:0] last_scl;
  logic        last_plain;
  assign last_ctl   = stage_ctrl[(NSTAGE-1)*14 +: 14];
  assign last_scl   = stage_scale[(NSTAGE-1)*18 +: 18];
  assign last_plain = last_ctl[13:12] == 2'd0 && last_scl[1:0] == 2'd0 && last_scl[17:16] == 2'd0;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_rgba));
  a_r4_const_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && last_plain && last_ctl[3:0] == 4'he)
      |=> out_rgba == $past(stage_const[(NSTAGE-1)*32 +: 32]));
  a_r7_seed_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && last_plain && last_ctl[3:0] == 4'hd && buf_mask[15:8] == 8'h00)
      |=> out_rgba == $past(buf_seed));
endmodule

bind frag_combiner frag_combiner_chk #(.NSTAGE(NSTAGE)) u_chk (.*);

// File: tb/tb_frag_combiner.sv
module tb_frag_combiner;
  localparam int NS = 6, NP = 4;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [NP*32-1:0] prim;
  logic [NS*14-1:0] stage_ctrl;
  logic [NS*18-1:0] stage_scale;
  logic [NS*32-1:0] stage_const;
  logic [31:0] buf_seed, buf_mask;
  logic out_valid;
  logic [31:0] out_rgba;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  frag_combiner dut (.clk, .rst_n, .in_valid, .prim, .stage_ctrl, .stage_scale,
                     .stage_const, .buf_seed, .buf_mask, .out_valid, .out_rgba);

  function automatic logic [7:0] m_ch(logic [1:0] op, int a, int b, int c, logic [1:0] sc);
    int t, k;
    case (op)
      0: t = a;
      1: t = (a + b > 255) ? 255 : a + b;
      2: begin t = a + b - 128; if (t < 0) t = 0; if (t > 255) t = 255; end
      default: t = (a * c + b * (255 - c)) / 255;
    endcase
    k = (sc == 1) ? 2 : (sc == 2) ? 4 : 1;
    t = t * k;
    return (t > 255) ? 8'hff : 8'(t);
  endfunction

  function automatic logic [31:0] m_sel(logic [3:0] s, logic [31:0] cst, logic [31:0] pv, logic [31:0] bf);
    if (s < NP) return prim[s*32 +: 32];
    if (s == 4'hd) return bf;
    if (s == 4'he) return cst;
    if (s == 4'hf) return pv;
    return 32'h0;
  endfunction

  function automatic logic [31:0] model();
    logic [31:0] pv, bf, a, b, c, r;
    logic [13:0] ct; logic [17:0] sc;
    pv = 0; bf = buf_seed;
    for (int s = 0; s < NS; s++) begin
      ct = stage_ctrl[s*14 +: 14]; sc = stage_scale[s*18 +: 18];
      a = m_sel(ct[3:0], stage_const[s*32 +: 32], pv, bf);
      b = m_sel(ct[7:4], stage_const[s*32 +: 32], pv, bf);
      c = m_sel(ct[11:8], stage_const[s*32 +: 32], pv, bf);
      for (int ch = 0; ch < 4; ch++)
        r[ch*8 +: 8] = m_ch(ct[13:12], int'(a[ch*8 +: 8]), int'(b[ch*8 +: 8]), int'(c[ch*8 +: 8]),
                            ch == 3 ? sc[17:16] : sc[1:0]);
      if (s < 4) begin
        if (buf_mask[8+s])  bf[23:0]  = r[23:0];
        if (buf_mask[12+s]) bf[31:24] = r[31:24];
      end
      pv = r;
    end
    return pv;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_stage(int s, logic [1:0] op, logic [3:0] a, logic [3:0] b, logic [3:0] c,
                           logic [1:0] cs, logic [1:0] as_);
    stage_ctrl[s*14 +: 14]  = {op, c, b, a};
    stage_scale[s*18 +: 18] = {as_, 14'd0, cs};
  endtask

  task automatic base_cfg();
    for (int s = 0; s < NS; s++) set_stage(s, 2'd0, 4'hf, 4'hf, 4'hf, 2'd0, 2'd0);
    buf_mask = 0;
  endtask

  task automatic run(string tag, logic [31:0] exp);
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check({tag, " R2 valid"}, {31'd0, out_valid}, 32'd1);
    check(tag, out_rgba, exp);
  endtask

  initial begin
    prim = '0; stage_ctrl = '0; stage_scale = '0; stage_const = '0;
    buf_seed = 0; buf_mask = 0;
    repeat (3) @(negedge clk);
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 data", out_rgba, 32'd0);
    rst_n = 1'b1;
    prim = {32'h44444444, 32'hA1B2C3D4, 32'h22222222, 32'h11111111};
    for (int s = 0; s < NS; s++) stage_const[s*32 +: 32] = 32'h10203040 + 32'(s);
    buf_seed = 32'h55667788;

    base_cfg(); set_stage(0, 0, 4'h2, 0, 0, 0, 0);
    run("R4 primary", 32'hA1B2C3D4);
    base_cfg(); set_stage(0, 0, 4'he, 0, 0, 0, 0);
    run("R4 const", 32'h10203040);
    base_cfg(); set_stage(0, 0, 4'h9, 0, 0, 0, 0);
    run("R4 unknown code", 32'h0);
    base_cfg();
    run("R4 stage0 previous", 32'h0);
    base_cfg(); set_stage(5, 0, 4'hd, 0, 0, 0, 0);
    run("R7 seed", 32'h55667788);

    base_cfg(); prim[31:0] = 32'h11223344; stage_const[63:32] = 32'hAABBCCDD;
    set_stage(0, 0, 4'h0, 0, 0, 0, 0); set_stage(1, 0, 4'he, 0, 0, 0, 0);
    set_stage(5, 0, 4'hd, 0, 0, 0, 0); buf_mask = 32'h0000_1200;
    run("R8 R9 split update", 32'h11BBCCDD);
    base_cfg(); set_stage(0, 0, 4'hd, 0, 0, 0, 0); buf_mask = 32'h0000_1100;
    run("R8 own stage sees old buffer", 32'h55667788);

    base_cfg(); prim[31:0] = 32'h0A0A0A0A; prim[63:32] = 32'hC8C8C8C8;
    set_stage(0, 2, 4'h0, 4'h0, 0, 0, 0);
    run("R5 add-signed low clamp", 32'h0);
    set_stage(0, 2, 4'h1, 4'h1, 0, 0, 0);
    run("R5 add-signed high clamp", 32'hFFFFFFFF);
    set_stage(0, 1, 4'h1, 4'h0, 0, 0, 0);
    run("R5 add", 32'hD2D2D2D2);
    prim[95:64] = 32'h80808080;
    set_stage(0, 3, 4'h1, 4'h0, 4'h2, 0, 0);
    run("R5 lerp", 32'h69696969);

    base_cfg(); prim[31:0] = 32'h3C3C3C3C;
    set_stage(0, 0, 4'h0, 0, 0, 1, 2);
    run("R6 scale 2x rgb 4x alpha", 32'hF0787878);
    set_stage(0, 0, 4'h0, 0, 0, 3, 0);
    run("R6 scale code 3", 32'h3C3C3C3C);
    prim[31:0] = 32'h64646464; set_stage(0, 0, 4'h0, 0, 0, 2, 1);
    run("R6 saturate", 32'hC8FFFFFF);

    @(negedge clk);
    prim = ~prim; buf_seed = ~buf_seed; stage_ctrl = ~stage_ctrl;
    @(negedge clk); @(negedge clk);
    check("R3 hold", out_rgba, 32'hC8FFFFFF);
    check("R2 idle valid", {31'd0, out_valid}, 32'd0);

    void'($urandom(32'd1234));
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < NP; i++) prim[i*32 +: 32] = $urandom;
      for (int s = 0; s < NS; s++) begin
        stage_const[s*32 +: 32] = $urandom;
        set_stage(s, 2'($urandom), 4'($urandom % 4 + ($urandom % 2) * 12), 4'($urandom),
                  4'($urandom), 2'($urandom), 2'($urandom));
      end
      buf_seed = $urandom; buf_mask = $urandom;
      run("R4 R5 R6 R8 random", model());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule